// File: doc/BRIEF.md
# Rolling Activation Window Limiter

This block paces row-activate commands for one memory rank. Two rules apply at once. Any two activates must be at least a programmable number of cycles apart. In addition, no more than a programmable count of activates (one to four) may fall inside a sliding window whose length is also programmable. A window length of zero switches the window rule off, which leaves only the spacing rule.

The command scheduler reads `act_ok_o` to learn whether an activate may go this cycle. It reads `next_ok_cycle_o` to learn the earliest cycle at which the next one may go. Both are given in the units of the block's own cycle counter, `now_o`. When the scheduler issues an activate it pulses `act_i`. An accepted activate is stamped into a short circular history, and the spacing and window checks are made against that history. A strobe that arrives while issue is not allowed is a protocol violation. It sets a sticky error flag and is left out of the history. All configuration inputs are expected to hold steady while the block is out of reset.

Top module: `actwin_limiter`

## Requirements
- R1: After an activate is accepted in the cycle where `now_o` = T, `act_ok_o` stays low until `now_o` reaches T + `cfg_rrd_i`. A spacing of 0 is treated as 1.
- R2: When `cfg_xaw_i` is nonzero and at least L activates have been recorded, issue is allowed only once `now_o` is at least the time of the L-th most recent accepted activate plus `cfg_xaw_i`.
- R3: The effective limit L is `cfg_limit_i` for values 1 to 4. A value of 0 acts as 1, and values 5 to 7 act as 4.
- R4: When `cfg_xaw_i` = 0 the window rule is off, and only the spacing rule governs issue.
- R5: While fewer than L activates have been recorded since reset, only the spacing rule applies. With nothing recorded, issue is always allowed.
- R6: `next_ok_cycle_o` equals the largest of `now_o`, the spacing due time and, when the window rule is active, the window due time. `act_ok_o` is high exactly when `next_ok_cycle_o` equals `now_o`.
- R7: An `act_i` pulse while `act_ok_o` is low sets `err_o` one cycle later. `err_o` stays set until reset. The rejected pulse is not recorded, so `next_ok_cycle_o` does not change.
- R8: While `rst_n` is low, `now_o` = 0, `next_ok_cycle_o` = 0, `act_ok_o` = 1, `err_o` = 0, and the history is empty.
- R9: `now_o` rises by exactly one on every clock edge after reset is released. The first cycle out of reset shows 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_i | input | 1 | Activate issued this cycle |
| cfg_rrd_i | input | DW | Minimum cycles between activates |
| cfg_xaw_i | input | DW | Window length in cycles, 0 disables the window rule |
| cfg_limit_i | input | CW | Activates allowed per window (1 to LIM_MAX) |
| act_ok_o | output | 1 | An activate may be issued this cycle |
| next_ok_cycle_o | output | TW | Earliest cycle value at which an activate may go |
| now_o | output | TW | Free-running cycle counter |
| err_o | output | 1 | Sticky flag for an activate issued when not allowed |

## Verification
`act_ok_o` and `next_ok_cycle_o` are combinational views of registered history. An activate accepted at the edge that ends cycle T therefore shows up in both outputs from cycle T+1 onward. `err_o` rises in the cycle after the offending strobe. The bench drives strobes on the falling edge and reads every result at the next falling edge. It compares the cycle in which `act_ok_o` first rises, read from `now_o`, against activate times it computes itself from the spacing, window and limit rules. It also checks `next_ok_cycle_o` in the first cycle after each accepted activate against the same computed time.

// File: rtl/actwin_pkg.sv
package actwin_pkg;

  // Effective window limit: values below one act as one, above the maximum act as the maximum.
  function automatic int eff_limit(input int raw, input int maxv);
    if (raw < 1) return 1;
    if (raw > maxv) return maxv;
    return raw;
  endfunction

  // Ring index that lies 'back' slots behind 'head' in a ring of 'depth' slots.
  function automatic int ring_back(input int head, input int back, input int depth);
    int idx;
    idx = head - back;
    if (idx < 0) idx = idx + depth;
    return idx;
  endfunction

  // Spacing of zero behaves as one cycle.
  function automatic int eff_spacing(input int raw);
    return (raw < 1) ? 1 : raw;
  endfunction

endpackage

// File: rtl/actwin_clock.sv
module actwin_clock #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] now_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign now_o = cnt_q;
endmodule

// File: rtl/actwin_history.sv
module actwin_history #(
  parameter int TW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [TW-1:0] stamp_i,
  input  logic [CW-1:0] back_i,
  output logic [TW-1:0] last_o,
  output logic [TW-1:0] oldest_o,
  output logic [CW-1:0] fill_o
);
  import actwin_pkg::*;

  logic [TW-1:0] stamp_q [DEPTH];
  logic [PW-1:0] head_q;
  logic [CW-1:0] fill_q;
  logic [PW-1:0] idx_last, idx_old;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                  stamp_q[gi] <= '0;
      else if (push_i && (head_q == PW'(gi)))      stamp_q[gi] <= stamp_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      fill_q <= '0;
    end else if (push_i) begin
      head_q <= (head_q == PW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
      if (fill_q < CW'(DEPTH)) fill_q <= fill_q + 1'b1;
    end
  end

  assign idx_last = PW'(ring_back(int'(head_q), 1, DEPTH));
  assign idx_old  = PW'(ring_back(int'(head_q), int'(back_i), DEPTH));
  assign last_o   = stamp_q[idx_last];
  assign oldest_o = stamp_q[idx_old];
  assign fill_o   = fill_q;

  // R5: each recorded activate grows the fill count until the ring is full
  assert_fill_grow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && fill_o < CW'(DEPTH)) |=> (fill_o == $past(fill_o) + 1'b1));

  // R5: the fill count never goes beyond the ring depth
  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o <= CW'(DEPTH));
endmodule

// File: rtl/actwin_gate.sv
module actwin_gate #(
  parameter int TW = 32,
  parameter int DW = 8,
  parameter int CW = 3
) (
  input  logic [TW-1:0] now_i,
  input  logic [TW-1:0] last_i,
  input  logic [TW-1:0] oldest_i,
  input  logic [CW-1:0] fill_i,
  input  logic [CW-1:0] lim_i,
  input  logic [DW-1:0] rrd_i,
  input  logic [DW-1:0] xaw_i,
  output logic          ok_o,
  output logic [TW-1:0] next_o,
  output logic          win_on_o
);
  import actwin_pkg::*;

  function automatic logic [TW-1:0] later_of(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [TW-1:0] rrd_w, xaw_w, sp_due, win_due;
  logic          have_last, sp_ok, win_ok;

  assign rrd_w     = TW'(eff_spacing(int'(rrd_i)));
  assign xaw_w     = TW'(xaw_i);
  assign have_last = (fill_i != '0);
  assign win_on_o  = (xaw_i != '0) && (fill_i >= lim_i);

  // Due times feed the earliest-cycle output.
  assign sp_due  = have_last ? (last_i + rrd_w) : '0;
  assign win_due = win_on_o ? (oldest_i + xaw_w) : '0;
  assign next_o  = later_of(now_i, later_of(sp_due, win_due));

  // The permission flag is formed separately from elapsed-time differences.
  assign sp_ok  = !have_last || ((now_i - last_i) >= rrd_w);
  assign win_ok = !win_on_o || ((now_i - oldest_i) >= xaw_w);
  assign ok_o   = sp_ok && win_ok;
endmodule

// File: rtl/actwin_limiter.sv
module actwin_limiter #(
  parameter int TW      = 32,
  parameter int DW      = 8,
  parameter int LIM_MAX = 4,
  parameter int CW      = $clog2(LIM_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic [DW-1:0] cfg_rrd_i,
  input  logic [DW-1:0] cfg_xaw_i,
  input  logic [CW-1:0] cfg_limit_i,
  output logic          act_ok_o,
  output logic [TW-1:0] next_ok_cycle_o,
  output logic [TW-1:0] now_o,
  output logic          err_o
);
  import actwin_pkg::*;

  logic [CW-1:0] lim_eff;
  logic [TW-1:0] last_t, oldest_t;
  logic [CW-1:0] fill;
  logic          accept, reject, win_on, err_q;

  assign lim_eff = CW'(eff_limit(int'(cfg_limit_i), LIM_MAX));
  assign accept  = act_i && act_ok_o;
  assign reject  = act_i && !act_ok_o;

  actwin_clock #(.TW(TW)) u_clock (
    .clk   (clk),
    .rst_n (rst_n),
    .now_o (now_o)
  );

  actwin_history #(.TW(TW), .DEPTH(LIM_MAX), .CW(CW)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_i   (accept),
    .stamp_i  (now_o),
    .back_i   (lim_eff),
    .last_o   (last_t),
    .oldest_o (oldest_t),
    .fill_o   (fill)
  );

  actwin_gate #(.TW(TW), .DW(DW), .CW(CW)) u_gate (
    .now_i    (now_o),
    .last_i   (last_t),
    .oldest_i (oldest_t),
    .fill_i   (fill),
    .lim_i    (lim_eff),
    .rrd_i    (cfg_rrd_i),
    .xaw_i    (cfg_xaw_i),
    .ok_o     (act_ok_o),
    .next_o   (next_ok_cycle_o),
    .win_on_o (win_on)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (reject) err_q <= 1'b1;
  end
  assign err_o = err_q;

  // R1: an accepted activate closes issue in the next cycle when the spacing exceeds one
  assert_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_rrd_i > 1) |=> !act_ok_o);

  // R2: with the window active and the spacing already met, issue waits on the window
  assert_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_on && act_ok_o) |-> (next_ok_cycle_o == now_o));

  // R5: an empty history never blocks issue
  assert_first_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |-> act_ok_o);

  // R6: the permission flag agrees with the earliest-cycle output
  assert_next_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act_ok_o == (next_ok_cycle_o == now_o));

  // R7: the error flag, once set, stays set
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R7: a rejected strobe leaves the earliest cycle unchanged and raises the error
  assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> ($stable(next_ok_cycle_o) && err_o));

  // R8: reset clears the counter and the error flag
  assert_reset_R8: assert property (@(posedge clk)
    !rst_n |=> (now_o == '0 && !err_o));

  // R9: the cycle counter advances by one per edge
  assert_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (now_o == $past(now_o) + 1'b1));
endmodule

// File: tb/actwin_limiter_tb.sv
module actwin_limiter_tb;
  localparam int TW = 32;
  localparam int DW = 8;
  localparam int CW = 3;
  localparam int NV = 8;
  localparam int NA = 8;
  // Each row: spacing, window, limit
  localparam int VEC [NV][3] = '{
    '{4, 24, 4}, '{8, 40, 2}, '{2, 0, 4}, '{1, 10, 1},
    '{3, 20, 0}, '{2, 30, 7}, '{5, 12, 4}, '{1, 9, 3}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          act_i = 1'b0;
  logic [DW-1:0] cfg_rrd_i = '0;
  logic [DW-1:0] cfg_xaw_i = '0;
  logic [CW-1:0] cfg_limit_i = '0;
  logic          act_ok_o;
  logic [TW-1:0] next_ok_cycle_o;
  logic [TW-1:0] now_o;
  logic          err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  actwin_limiter #(.TW(TW), .DW(DW), .LIM_MAX(4), .CW(CW)) u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .act_i           (act_i),
    .cfg_rrd_i       (cfg_rrd_i),
    .cfg_xaw_i       (cfg_xaw_i),
    .cfg_limit_i     (cfg_limit_i),
    .act_ok_o        (act_ok_o),
    .next_ok_cycle_o (next_ok_cycle_o),
    .now_o           (now_o),
    .err_o           (err_o)
  );

  task automatic chk(input bit cond, input string req, input longint actual, input longint expected);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic do_reset(input int r, input int x, input int l);
    act_i = 1'b0;
    rst_n = 1'b0;
    cfg_rrd_i = DW'(r);
    cfg_xaw_i = DW'(x);
    cfg_limit_i = CW'(l);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_ok();
    for (int g = 0; g < 300 && !act_ok_o; g++) @(negedge clk);
  endtask

  task automatic run_vec(input int r, input int x, input int l);
    longint t [NA];
    int le, re;
    string tg;
    le = (l < 1) ? 1 : ((l > 4) ? 4 : l);
    re = (r < 1) ? 1 : r;
    do_reset(r, x, l);
    t[0] = longint'(now_o);
    for (int k = 0; k < NA; k++) begin
      if (k > 0) begin
        t[k] = t[k-1] + re;
        if (x != 0 && k >= le && t[k-le] + x > t[k]) t[k] = t[k-le] + x;
        // R6: first cycle after the previous accept announces the due time
        chk(next_ok_cycle_o == TW'(t[k]), "R6", longint'(next_ok_cycle_o), t[k]);
      end
      if (x == 0)               tg = "R4";
      else if (l < 1 || l > 4)  tg = "R3";
      else if (k < le)          tg = "R5";
      else                      tg = "R2";
      wait_ok();
      chk(now_o == TW'(t[k]), tg, longint'(now_o), t[k]);
      act_i = 1'b1;
      @(negedge clk);
      act_i = 1'b0;
    end
    chk(err_o == 1'b0, "R7", longint'(err_o), 0);
  endtask

  initial begin
    // R8: state held in reset
    cfg_rrd_i = 8'd3;
    repeat (3) @(negedge clk);
    chk(now_o == '0, "R8", longint'(now_o), 0);
    chk(act_ok_o == 1'b1, "R8", longint'(act_ok_o), 1);
    chk(err_o == 1'b0, "R8", longint'(err_o), 0);
    chk(next_ok_cycle_o == '0, "R8", longint'(next_ok_cycle_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: counter starts at one after release and steps by one
    chk(now_o == 32'd1, "R9", longint'(now_o), 1);
    repeat (5) @(negedge clk);
    chk(now_o == 32'd6, "R9", longint'(now_o), 6);

    for (int v = 0; v < NV; v++) run_vec(VEC[v][0], VEC[v][1], VEC[v][2]);

    // R1 and R7: rejected strobe during the spacing gap
    do_reset(6, 0, 4);
    chk(act_ok_o == 1'b1, "R5", longint'(act_ok_o), 1);
    act_i = 1'b1;                       // accepted at now = 1
    @(negedge clk);
    act_i = 1'b0;
    chk(act_ok_o == 1'b0, "R1", longint'(act_ok_o), 0);
    chk(next_ok_cycle_o == 32'd7, "R1", longint'(next_ok_cycle_o), 7);
    act_i = 1'b1;                       // illegal at now = 2
    @(negedge clk);
    act_i = 1'b0;
    chk(err_o == 1'b1, "R7", longint'(err_o), 1);
    chk(next_ok_cycle_o == 32'd7, "R7", longint'(next_ok_cycle_o), 7);
    wait_ok();
    chk(now_o == 32'd7, "R7", longint'(now_o), 7);
    act_i = 1'b1;
    @(negedge clk);
    act_i = 1'b0;
    chk(err_o == 1'b1, "R7", longint'(err_o), 1);
    chk(next_ok_cycle_o == 32'd13, "R1", longint'(next_ok_cycle_o), 13);
    rst_n = 1'b0;
    @(negedge clk);
    chk(err_o == 1'b0, "R8", longint'(err_o), 0);

    // R1: spacing of zero behaves as one, so back-to-back issue is allowed
    do_reset(0, 0, 4);
    act_i = 1'b1;
    @(negedge clk);
    chk(act_ok_o == 1'b1, "R1", longint'(act_ok_o), 1);
    @(negedge clk);
    act_i = 1'b0;
    chk(err_o == 1'b0, "R1", longint'(err_o), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule